// File: doc/BRIEF.md
# SPI Channel Register and FIFO Frontend

This block is the software-facing half of a single SPI channel. It sits on a simple 32-bit word-addressed read/write port. It holds the channel's mode settings, the serial clock divider, the transfer command, the sticky status flags, the interrupt enables and the FIFO threshold settings. It also contains two eight-word, 32-bit FIFOs. Software fills the transmit FIFO and drains the receive FIFO. A separate serial engine pops transmit words, pushes received words and signals the end of each transfer.

Writing the command register latches the direction, continue and bit-count fields for the engine. The same write raises a one-cycle launch pulse and marks a transfer as pending. Status flags stay set until software writes a one to them. Each flag is gated by its own enable bit, and the gated flags are combined into one level interrupt.

Register word addresses (byte offset / 4): 0 mode, 1 divider, 2 command, 3 status, 4 interrupt enable, 5 threshold, 6 FIFO levels, 7 transmit data, 8 receive data. Every other address reads zero and ignores writes.

Top module: `spi_ctrl_frontend`

## Requirements
- R1: After reset, the registers read as follows. Mode reads 0. Divider reads 4. Interrupt enable reads 0. Threshold reads 0x80. FIFO levels read 0. Status reads 0x04, because only the TX-threshold flag is set, the empty TX FIFO being at or below threshold 0. The irq output is 0.
- R2: A write to the mode register (address 0) keeps only bits 0-5, 10 and 11. The other bits read back as zero. The stored value also drives `cfg_word`.
- R3: A write to the divider register (address 1) stores the written 32-bit value clamped to the range 4 to 65535. The stored value drives `div_value`.
- R4: A write to the command register (address 2) stores the value masked with 0xFFFF0013. That is direction in bits [1:0], continue in bit 4 and bit count in [31:16]. The stored value drives `cmd_word`. In the cycle after the write, `cmd_start` is high for exactly one cycle and status bit 0 (pending) is set.
- R5: A pulse on `eng_done` clears pending (status bit 0) and sets done (status bit 1).
- R6: A write to status (address 3) clears each of bits 1-5 that is written as 1. Bits written as 0 are left unchanged. Pending (bit 0) cannot be changed by a write.
- R7: Each write to address 7 pushes one word into the 8-word TX FIFO. A write to a full TX FIFO is dropped. The engine receives the words in write order. The TX fill level reads at FIFO-levels bits [7:4].
- R8: The engine pushes words into the 8-word RX FIFO, and each read of address 8 pops one word in arrival order. A read of an empty RX FIFO returns 0. The RX fill level reads at FIFO-levels bits [3:0].
- R9: Status bit 2 is set while the TX level is at or below threshold bits [3:0]. Status bit 3 is set while the RX level is at or above threshold bits [7:4]. A cleared threshold flag sets again while its condition holds.
- R10: An engine pop from an empty TX FIFO returns 0 and sets status bit 4 (underflow). An engine push into a full RX FIFO drops the word and sets status bit 5 (overflow).
- R11: `irq` is high exactly when any of these pairs are both set:
  - status bit 1 and enable bit 0
  - status bit 2 and enable bit 1
  - status bit 3 and enable bit 2
  - status bit 4 and enable bit 3
  - status bit 5 and enable bit 4
- R12: Addresses 9 to 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX FIFO at address 8) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Level interrupt |
| cfg_word | output | 12 | Stored mode bits for the engine |
| div_value | output | 16 | Stored clock divider |
| cmd_start | output | 1 | One-cycle transfer launch pulse |
| cmd_word | output | 32 | Stored command fields |
| eng_tx_pop | input | 1 | Engine takes the TX head word |
| eng_tx_data | output | 32 | TX head word, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_done | input | 1 | Engine finished the current transfer |

## Verification
A wrong FIFO pointer or count shows up at the FIFO-levels register in the same cycle. It then shows up as reordered or zero data at the next pop, either at `eng_tx_data` or through the receive data register. A corrupted status or enable bit reaches `irq` combinationally in the cycle after the faulty update. Threshold errors appear one cycle after the level crosses, because the flags are registered from the counts. A bad clamp or mask is visible on the first read-back of the register concerned.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  // byte offsets of the registers; word address = offset / 4
  localparam int OFF_CFG  = 'h00;
  localparam int OFF_DIV  = 'h04;
  localparam int OFF_CMD  = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_IEN  = 'h10;
  localparam int OFF_THR  = 'h14;
  localparam int OFF_LVL  = 'h18;
  localparam int OFF_TXD  = 'h1C;
  localparam int OFF_RXD  = 'h20;

  localparam logic [11:0] CFG_KEEP = 12'hC3F;
  localparam logic [31:0] CMD_KEEP = 32'hFFFF_0013;
  localparam logic [7:0]  THR_INIT = 8'h80;
  localparam logic [31:0] DIV_LO   = 32'd4;
  localparam logic [31:0] DIV_HI   = 32'd65535;

  // status bit positions
  localparam int ST_PEND = 0;
  localparam int ST_DONE = 1;
  localparam int ST_TXTH = 2;
  localparam int ST_RXTH = 3;
  localparam int ST_TXUF = 4;
  localparam int ST_RXOF = 5;

  function automatic logic [15:0] clamp_div(input logic [31:0] v);
    if (v < DIV_LO)      return DIV_LO[15:0];
    else if (v > DIV_HI) return DIV_HI[15:0];
    else                 return v[15:0];
  endfunction

  // status flags [5:1] gated by enable bits [4:0]
  function automatic logic irq_from(input logic [5:0] st, input logic [4:0] ie);
    return |(st[5:1] & ie);
  endfunction
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7 / R8: level never exceeds the depth
  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R7: a push into a full FIFO without a pop leaves it full
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  // R8: a pop of an empty FIFO without a push leaves it empty
  p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/spi_fe_status.sv
module spi_fe_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend_set,
  input  logic       pend_clr,
  input  logic [5:1] flag_set,
  input  logic [5:1] flag_clr,
  input  logic [4:0] ien,
  output logic [5:0] status,
  output logic       irq
);
  import spi_fe_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      // launch wins over end in the same cycle
      status[ST_PEND] <= pend_set | (status[ST_PEND] & ~pend_clr);
      // a new event wins over a write-one clear in the same cycle
      status[5:1]     <= (status[5:1] & ~flag_clr) | flag_set;
    end
  end

  assign irq = irq_from(status, ien);

  // R5: an end-of-transfer leaves done set
  p_done_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> status[ST_DONE]);
  // R6: pending moves only on launch or end
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_set && !pend_clr) |=> (status[ST_PEND] == $past(status[ST_PEND])));
  // R11: nothing enabled, no interrupt
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: rtl/spi_ctrl_frontend.sv
module spi_ctrl_frontend #(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [11:0]       cfg_word,
  output logic [15:0]       div_value,
  output logic              cmd_start,
  output logic [31:0]       cmd_word,
  input  logic              eng_tx_pop,
  output logic [31:0]       eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [31:0]       eng_rx_data,
  input  logic              eng_done
);
  import spi_fe_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG  / 4);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFF_DIV  / 4);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD  / 4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT / 4);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN  / 4);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFF_THR  / 4);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(OFF_LVL  / 4);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFF_TXD  / 4);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFF_RXD  / 4);

  logic [4:0]       ien_q;
  logic [7:0]       thr_q;
  logic [5:0]       status;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [31:0]      rx_head;

  // named internal events
  logic       wr_cmd, wr_stat, wr_txd, rd_rxd;
  logic       tx_low, rx_high, tx_under, rx_over;
  logic [5:1] flag_set, flag_clr;

  assign wr_cmd   = bus_wr && (bus_addr == A_CMD);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);
  assign wr_txd   = bus_wr && (bus_addr == A_TXD);
  assign rd_rxd   = bus_rd && (bus_addr == A_RXD);
  assign tx_low   = 4'(tx_cnt) <= thr_q[3:0];
  assign rx_high  = 4'(rx_cnt) >= thr_q[7:4];
  assign tx_under = eng_tx_pop && tx_empty;
  assign rx_over  = eng_rx_push && rx_full;

  assign flag_set = {rx_over, tx_under, rx_high, tx_low, eng_done};
  assign flag_clr = wr_stat ? bus_wdata[5:1] : 5'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word  <= '0;
      div_value <= DIV_LO[15:0];
      cmd_word  <= '0;
      cmd_start <= 1'b0;
      ien_q     <= '0;
      thr_q     <= THR_INIT;
    end else begin
      cmd_start <= wr_cmd;
      if (bus_wr) begin
        case (bus_addr)
          A_CFG:   cfg_word  <= bus_wdata[11:0] & CFG_KEEP;
          A_DIV:   div_value <= clamp_div(bus_wdata);
          A_CMD:   cmd_word  <= bus_wdata & CMD_KEEP;
          A_IEN:   ien_q     <= bus_wdata[4:0];
          A_THR:   thr_q     <= bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  spi_fe_fifo #(.W(32), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(wr_txd), .din(bus_wdata),
    .pop(eng_tx_pop), .dout(eng_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spi_fe_fifo #(.W(32), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(rd_rxd), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  spi_fe_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .pend_set(wr_cmd), .pend_clr(eng_done),
    .flag_set(flag_set), .flag_clr(flag_clr),
    .ien(ien_q), .status(status), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {20'b0, cfg_word};
      A_DIV:   bus_rdata = {16'b0, div_value};
      A_CMD:   bus_rdata = cmd_word;
      A_STAT:  bus_rdata = {26'b0, status};
      A_IEN:   bus_rdata = {27'b0, ien_q};
      A_THR:   bus_rdata = {24'b0, thr_q};
      A_LVL:   bus_rdata = {24'b0, 4'(tx_cnt), 4'(rx_cnt)};
      A_RXD:   bus_rdata = rx_head;
      default: bus_rdata = '0;
    endcase
  end

  // R3: divider never leaves its legal range
  p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_value >= 16'd4));
  // R4: a launch pulse is always accompanied by pending
  p_launch_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> status[ST_PEND]);
  // R10: an engine pop of an empty TX FIFO sees zero data
  p_under_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_under |-> (eng_tx_data == 32'b0));
  // R8: an empty RX FIFO reads zero
  p_rx_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && bus_addr == A_RXD) |-> (bus_rdata == 32'b0));
  // R7: a full TX FIFO reports the full level
  p_tx_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> (bus_addr != A_LVL || bus_rdata[7:4] == 4'(DEPTH)));
endmodule

// File: tb/sim_spi_ctrl_frontend.sv
module sim_spi_ctrl_frontend;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq, cmd_start;
  logic [11:0] cfg_word;
  logic [15:0] div_value;
  logic [31:0] cmd_word, eng_tx_data;
  logic        eng_tx_pop = 0, eng_rx_push = 0, eng_done = 0;
  logic [31:0] eng_rx_data = 0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_ctrl_frontend u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cfg_word(cfg_word), .div_value(div_value),
    .cmd_start(cmd_start), .cmd_word(cmd_word),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_done(eng_done)
  );

  function automatic logic [31:0] want_div(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    if (r > 32'hFFFF) r = 32'hFFFF;
    if (r < 32'd4) r = 32'd4;
    return r;
  endfunction

  function automatic bit want_irq(input logic [31:0] st, input logic [31:0] ie);
    bit r;
    r = 0;
    for (int k = 0; k < 5; k++) if (st[k+1] && ie[k]) r = 1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic eng_pop(output logic [31:0] d);
    @(negedge clk);
    eng_tx_pop = 1;
    #1 d = eng_tx_data;
    @(posedge clk); #1;
    eng_tx_pop = 0;
  endtask

  task automatic eng_push(input logic [31:0] d);
    @(negedge clk);
    eng_rx_push = 1; eng_rx_data = d;
    @(posedge clk); #1;
    eng_rx_push = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    logic [31:0] q [16];
    int n, seed;
    seed = 1234;
    v = $urandom(seed);

    idle(2); @(negedge clk); rst_n = 1; idle(2);

    // R1 reset state
    rd(0, v); check("R1 mode", v, 0);
    rd(1, v); check("R1 divider", v, 4);
    rd(3, v); check("R1 status", v, 32'h04);
    rd(4, v); check("R1 enable", v, 0);
    rd(5, v); check("R1 threshold", v, 32'h80);
    rd(6, v); check("R1 levels", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 mode mask
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check("R2 mode readback", v, 32'hC3F);
    check("R2 cfg_word", {20'b0, cfg_word}, 32'hC3F);
    wr(0, 32'h0000_0405);
    rd(0, v); check("R2 mode partial", v, 32'h405);

    // R3 divider clamp, directed then random
    foreach (q[i]) q[i] = 0;
    q[0] = 0; q[1] = 3; q[2] = 4; q[3] = 65535; q[4] = 65536; q[5] = 32'hFFFF_FFFF;
    for (int i = 6; i < 12; i++) q[i] = ($urandom() & 1) ? $urandom() : ($urandom() & 32'h1FFFF);
    for (int i = 0; i < 12; i++) begin
      wr(1, q[i]);
      rd(1, v); check("R3 divider", v, want_div(q[i]));
      check("R3 div_value", {16'b0, div_value}, want_div(q[i]));
    end

    // R4 command launch
    wr(2, 32'hABCD_00FF);
    check("R4 cmd_start high", {31'b0, cmd_start}, 1);
    check("R4 cmd_word", cmd_word, 32'hABCD_0013);
    idle(1);
    check("R4 cmd_start one cycle", {31'b0, cmd_start}, 0);
    rd(2, v); check("R4 cmd readback", v, 32'hABCD_0013);
    rd(3, v); check("R4 pending set", v & 1, 1);

    // R6 pending not writable
    wr(3, 32'h3F);
    rd(3, v); check("R6 pending survives write", v & 1, 1);

    // R5 end of transfer
    @(negedge clk); eng_done = 1; @(posedge clk); #1; eng_done = 0;
    rd(3, v); check("R5 pending cleared", v & 1, 0);
    check("R5 done set", v & 2, 2);
    wr(3, 32'h0);
    rd(3, v); check("R6 zero write keeps done", v & 2, 2);
    wr(3, 32'h2);
    rd(3, v); check("R6 done cleared", v & 2, 0);

    // R7 / R10 TX path, random rounds
    for (int r = 0; r < 4; r++) begin
      n = (r == 0) ? 11 : int'($urandom_range(1, 10));
      for (int i = 0; i < n; i++) begin
        q[i] = $urandom();
        wr(7, q[i]);
      end
      rd(6, v); check("R7 tx level", v[7:4], (n > 8) ? 8 : n);
      for (int i = 0; i < ((n > 8) ? 8 : n); i++) begin
        eng_pop(v); check("R7 tx order", v, q[i]);
      end
      rd(3, v); check("R10 no underflow yet", v & 32'h10, 0);
      eng_pop(v); check("R10 underflow data", v, 0);
      rd(3, v); check("R10 underflow flag", v & 32'h10, 32'h10);
      wr(3, 32'h3E);
    end

    // R9 TX threshold
    wr(5, 32'h82);
    for (int i = 0; i < 3; i++) wr(7, i);
    idle(1);
    wr(3, 32'h04); idle(1);
    rd(3, v); check("R9 tx above threshold", v & 4, 0);
    eng_pop(v); idle(1);
    rd(3, v); check("R9 tx at threshold", v & 4, 4);
    wr(3, 32'h04); idle(1);
    rd(3, v); check("R9 tx flag re-sets", v & 4, 4);
    eng_pop(v); eng_pop(v);

    // R8 / R10 RX path, random rounds
    for (int r = 0; r < 4; r++) begin
      wr(3, 32'h3E);
      n = (r == 0) ? 10 : int'($urandom_range(1, 9));
      for (int i = 0; i < n; i++) begin
        q[i] = $urandom();
        eng_push(q[i]);
      end
      rd(6, v); check("R8 rx level", v[3:0], (n > 8) ? 8 : n);
      rd(3, v); check("R10 overflow flag", v & 32'h20, (n > 8) ? 32'h20 : 0);
      for (int i = 0; i < ((n > 8) ? 8 : n); i++) begin
        rd(8, v); check("R8 rx order", v, q[i]);
      end
      rd(8, v); check("R8 empty read zero", v, 0);
    end

    // R9 RX threshold at 3
    wr(5, 32'h30);
    wr(3, 32'h3E);
    eng_push(1); eng_push(2); idle(1);
    wr(3, 32'h08); idle(1);
    rd(3, v); check("R9 rx below threshold", v & 8, 0);
    eng_push(3); idle(1);
    rd(3, v); check("R9 rx at threshold", v & 8, 8);
    rd(8, v); rd(8, v); rd(8, v);

    // R11 interrupt combining, random enables
    eng_pop(v);
    for (int r = 0; r < 10; r++) begin
      e = $urandom() & 32'h1F;
      wr(4, e);
      rd(3, v);
      check("R11 irq", {31'b0, irq}, {31'b0, want_irq(v, e)});
    end
    wr(4, 32'h01); wr(3, 32'h3E); idle(1);
    check("R11 done masked low", {31'b0, irq}, 0);
    @(negedge clk); eng_done = 1; @(posedge clk); #1; eng_done = 0;
    check("R11 done raises irq", {31'b0, irq}, 1);
    wr(3, 32'h02);
    check("R11 irq drops on clear", {31'b0, irq}, 0);

    // R12 unmapped addresses
    rd(4, e);
    for (int a = 9; a < 16; a++) begin
      wr(a[3:0], 32'hFFFF_FFFF);
      rd(a[3:0], v); check("R12 unmapped read", v, 0);
    end
    rd(0, v); check("R12 mode untouched", v, 32'h405);
    rd(4, v); check("R12 enable untouched", v, e);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule